// File: doc/BRIEF.md
# Streaming Planar Intra Predictor (16x16 Luma)

This block generates the planar-mode prediction for one 16x16 luma block and streams it out one sample per clock in raster order. Every output sample is the rounded average of two linear ramps. One ramp runs across the row, from that row's left neighbour toward the top-right corner sample. The other runs down the column, from that column's top neighbour toward the bottom-left corner sample.

A single-cycle `start` pulse captures the 16 left neighbours, the 16 top neighbours and the two corner samples. The block then walks a pair of 4-bit position counters through all 256 positions, with the column moving fastest. Each result leaves a register stage together with its column, row and valid flag. A one-cycle `block_done` follows the last position. A start that arrives while the last position is being produced begins the next block at once, so consecutive blocks stream with no gap.

Top module: `planar_pred16`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, the next outputs are `pred_valid`=0, `block_done`=0, `pred_col`=0, `pred_row`=0 and `pred_sample`=0. A scan in progress is abandoned and produces no `block_done`.
- R2: A `start` accepted on a rising edge makes `pred_valid` rise on the following edge, and the first valid position is column 0, row 0.
- R3: Once started, `pred_valid` stays high for exactly 256 consecutive cycles. The column increments by one each cycle. From column 15 it wraps to 0 and the row increments, ending at column 15, row 15.
- R4: Each valid `pred_sample` at column i and row j equals ((15-i)*L[j] + (i+1)*TR + (15-j)*T[i] + (j+1)*BL + 16) >> 5. L[j] is bits [8j+7:8j] of `ref_left`, T[i] is bits [8i+7:8i] of `ref_top`, TR is `ref_top_right` and BL is `ref_bot_left`, all unsigned.
- R5: `block_done` is high for exactly one cycle, namely the cycle right after the output showed column 15, row 15. If no new block was chained, `pred_valid` is low in that cycle.
- R6: A `start` that arrives while a scan is running, before its final position, is ignored. The position sequence continues and the samples keep using the references captured at the accepted start.
- R7: A `start` held high during the cycle in which the output shows column 14, row 15 is accepted. The new block's column 0, row 0 then appears right after column 15, row 15, in the same cycle as `block_done`.
- R8: The result is never clipped and stays within 8 bits. All references at 0 give 0 everywhere, and all references at 255 give 255 everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture the references and begin a block |
| ref_left | input | 128 | Left neighbours, row j at bits [8j+7:8j] |
| ref_top | input | 128 | Top neighbours, column i at bits [8i+7:8i] |
| ref_top_right | input | 8 | Top-right corner sample |
| ref_bot_left | input | 8 | Bottom-left corner sample |
| pred_sample | output | 8 | Predicted sample |
| pred_col | output | 4 | Column of the current sample |
| pred_row | output | 4 | Row of the current sample |
| pred_valid | output | 1 | Sample, column and row are valid |
| block_done | output | 1 | One-cycle pulse after the final position |

## Verification
Two events can fall in the same cycle: the end-of-block pulse of one block and the first valid sample of the next. The bench provokes this by raising `start`, with a fresh set of references, during the cycle that shows column 14, row 15. In the following cycles it checks three things. The old block's final sample must still use the old references. The next cycle must carry `block_done` together with a valid sample at column 0, row 0 computed from the new references. The new block must then run through its own complete sequence.

// File: rtl/planar_pred_pkg.sv
// Package: shared defaults for the planar predictor.
// Assumes: the block edge is a power of two and samples are unsigned.
package planar_pred_pkg;
    localparam int PP_SAMPLE_W = 8;   // bits per reference and predicted sample
    localparam int PP_LOG2_N   = 4;   // log2 of the block edge (16)
endpackage

// File: rtl/pp_blend.sv
// Module: pp_blend
// Combinational planar blend for one position. It selects the left
// neighbour of the row and the top neighbour of the column, weights both
// against the corner samples, adds the rounding offset and shifts.
// Assumes: the references are stable while col/row are used. Since the
// weights sum to the block edge, the result fits SAMPLE_W bits unclipped.
module pp_blend #(
    parameter int SAMPLE_W = 8,
    parameter int LOG2_N   = 4
) (
    input  logic [(SAMPLE_W<<LOG2_N)-1:0] left_bus,
    input  logic [(SAMPLE_W<<LOG2_N)-1:0] top_bus,
    input  logic [SAMPLE_W-1:0]           corner_tr,
    input  logic [SAMPLE_W-1:0]           corner_bl,
    input  logic [LOG2_N-1:0]             col,
    input  logic [LOG2_N-1:0]             row,
    output logic [SAMPLE_W-1:0]           sample
);
    localparam int N     = 1 << LOG2_N;
    localparam int WT_W  = LOG2_N + 1;
    localparam int ACC_W = SAMPLE_W + LOG2_N + 2;

    logic [SAMPLE_W-1:0] left_arr [N];
    logic [SAMPLE_W-1:0] top_arr  [N];

    // Unpack the flat neighbour buses into indexed arrays.
    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign left_arr[g] = left_bus[g*SAMPLE_W +: SAMPLE_W];
        assign top_arr[g]  = top_bus[g*SAMPLE_W +: SAMPLE_W];
    end

    logic [WT_W-1:0]  w_left, w_tr, w_top, w_bl;
    logic [ACC_W-1:0] horiz, vert, total;

    // Ramp weights, the two weighted sums, rounding and normalisation.
    always_comb begin
        w_left = WT_W'(N - 1) - {1'b0, col};
        w_tr   = {1'b0, col} + WT_W'(1);
        w_top  = WT_W'(N - 1) - {1'b0, row};
        w_bl   = {1'b0, row} + WT_W'(1);
        horiz  = ACC_W'(w_left) * ACC_W'(left_arr[row])
               + ACC_W'(w_tr)   * ACC_W'(corner_tr);
        vert   = ACC_W'(w_top)  * ACC_W'(top_arr[col])
               + ACC_W'(w_bl)   * ACC_W'(corner_bl);
        total  = horiz + vert + ACC_W'(N);
        sample = SAMPLE_W'(total >> (LOG2_N + 1));
    end
endmodule

// File: rtl/pp_ref_store.sv
// Module: pp_ref_store
// Holds the neighbour samples and corners captured on an accepted start.
// Assumes: load is asserted only when the scan controller accepts a start.
// The data registers have no reset because nothing reads them before a load.
module pp_ref_store #(
    parameter int SAMPLE_W = 8,
    parameter int LOG2_N   = 4
) (
    input  logic                          clk,
    input  logic                          load,
    input  logic [(SAMPLE_W<<LOG2_N)-1:0] left_in,
    input  logic [(SAMPLE_W<<LOG2_N)-1:0] top_in,
    input  logic [SAMPLE_W-1:0]           tr_in,
    input  logic [SAMPLE_W-1:0]           bl_in,
    output logic [(SAMPLE_W<<LOG2_N)-1:0] left_q,
    output logic [(SAMPLE_W<<LOG2_N)-1:0] top_q,
    output logic [SAMPLE_W-1:0]           tr_q,
    output logic [SAMPLE_W-1:0]           bl_q
);
    // Capture all references together when a block is accepted.
    always_ff @(posedge clk) begin
        if (load) begin
            left_q <= left_in;
            top_q  <= top_in;
            tr_q   <= tr_in;
            bl_q   <= bl_in;
        end
    end
endmodule

// File: rtl/pp_scan_ctrl.sv
// Module: pp_scan_ctrl
// Raster position generator. It advances the column every cycle, and on
// the column wrap it advances the row. It accepts a start when idle or
// on the final position, which lets blocks run back to back.
// Assumes: synchronous active-low reset.
module pp_scan_ctrl #(
    parameter int LOG2_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic [LOG2_N-1:0] col,
    output logic [LOG2_N-1:0] row
);
    localparam logic [LOG2_N-1:0] LAST = '1;

    logic at_last;

    // Detect the final position and decide whether a start is taken.
    always_comb begin
        at_last = busy && (col == LAST) && (row == LAST);
        accept  = start && (!busy || at_last);
    end

    // Step the position counters through the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            col  <= '0;
            row  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            col  <= '0;
            row  <= '0;
        end else if (busy) begin
            if (at_last) begin
                busy <= 1'b0;
            end else if (col == LAST) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/planar_pred16.sv
// Module: planar_pred16 (top)
// Streams the planar prediction of one block, one sample per clock.
// Scan counters and captured references feed a combinational blend. One
// output register stage then aligns the sample, position, valid and
// done so they all change on the same edge.
// Assumes: references are valid on the cycle start is high.
module planar_pred16
    import planar_pred_pkg::*;
#(
    parameter int SAMPLE_W = PP_SAMPLE_W,
    parameter int LOG2_N   = PP_LOG2_N
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [(SAMPLE_W<<LOG2_N)-1:0] ref_left,
    input  logic [(SAMPLE_W<<LOG2_N)-1:0] ref_top,
    input  logic [SAMPLE_W-1:0]           ref_top_right,
    input  logic [SAMPLE_W-1:0]           ref_bot_left,
    output logic [SAMPLE_W-1:0]           pred_sample,
    output logic [LOG2_N-1:0]             pred_col,
    output logic [LOG2_N-1:0]             pred_row,
    output logic                          pred_valid,
    output logic                          block_done
);
    localparam int BUS_W = SAMPLE_W << LOG2_N;
    localparam logic [LOG2_N-1:0] LAST = '1;

    logic                accept, busy;
    logic [LOG2_N-1:0]   scan_col, scan_row;
    logic [BUS_W-1:0]    left_q, top_q;
    logic [SAMPLE_W-1:0] tr_q, bl_q, blend_out;

    pp_scan_ctrl #(.LOG2_N(LOG2_N)) scan_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .busy(busy), .col(scan_col), .row(scan_row)
    );

    pp_ref_store #(.SAMPLE_W(SAMPLE_W), .LOG2_N(LOG2_N)) refs_i (
        .clk(clk), .load(accept),
        .left_in(ref_left), .top_in(ref_top),
        .tr_in(ref_top_right), .bl_in(ref_bot_left),
        .left_q(left_q), .top_q(top_q), .tr_q(tr_q), .bl_q(bl_q)
    );

    pp_blend #(.SAMPLE_W(SAMPLE_W), .LOG2_N(LOG2_N)) blend_i (
        .left_bus(left_q), .top_bus(top_q),
        .corner_tr(tr_q), .corner_bl(bl_q),
        .col(scan_col), .row(scan_row), .sample(blend_out)
    );

    // Output stage: register the sample with its position, valid and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_sample <= '0;
            pred_col    <= '0;
            pred_row    <= '0;
            pred_valid  <= 1'b0;
            block_done  <= 1'b0;
        end else begin
            pred_sample <= blend_out;
            pred_col    <= scan_col;
            pred_row    <= scan_row;
            pred_valid  <= busy;
            block_done  <= pred_valid && (pred_col == LAST) && (pred_row == LAST);
        end
    end
endmodule

// File: rtl/planar_pred16_chk.sv
// Module: planar_pred16_chk
// Temporal checks on the predictor's output ports, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module planar_pred16_chk #(
    parameter int LOG2_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              done,
    input logic [LOG2_N-1:0] col,
    input logic [LOG2_N-1:0] row
);
    localparam logic [LOG2_N-1:0] LAST = '1;

    // R1: a reset edge leaves valid and done low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid && !done));

    // R2: every block begins at the origin.
    assert_first_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (col == '0 && row == '0));

    // R3: inside a row the column steps by one and the row holds.
    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && col != LAST) |=> (valid && col == $past(col) + 1'b1 && row == $past(row)));

    // R3: at the end of a row the column wraps and the row advances.
    assert_row_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && col == LAST && row != LAST) |=> (valid && col == '0 && row == $past(row) + 1'b1));

    // R5: the final position is followed by done.
    assert_done_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && col == LAST && row == LAST) |=> done);

    // R5: done lasts a single cycle.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind planar_pred16 planar_pred16_chk #(.LOG2_N(LOG2_N)) chk_i (
    .clk(clk), .rst_n(rst_n), .valid(pred_valid), .done(block_done),
    .col(pred_col), .row(pred_row)
);

// File: tb/planar_pred16_tb_top.sv
module planar_pred16_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [127:0] left_bus, top_bus;
    logic [7:0] tr_in = '0, bl_in = '0;
    logic [7:0] pred_sample;
    logic [3:0] pred_col, pred_row;
    logic pred_valid, block_done;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] d_left [16];
    logic [7:0] d_top  [16];
    logic [7:0] e_left [16];
    logic [7:0] e_top  [16];
    logic [7:0] e_tr, e_bl;
    int first_pred, last_pred;

    // Uniform-reference vectors: {left, top, top_right, bot_left, exp(0,0), exp(15,15)}
    localparam logic [47:0] VEC [5] = '{
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
        {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        {8'd0,   8'd0,   8'd255, 8'd255, 8'd16,  8'd255},
        {8'd255, 8'd255, 8'd0,   8'd0,   8'd239, 8'd0},
        {8'd100, 8'd200, 8'd0,   8'd50,  8'd142, 8'd25}
    };

    always #5ns clk = ~clk;

    always_comb begin
        for (int g = 0; g < 16; g++) begin
            left_bus[g*8 +: 8] = d_left[g];
            top_bus[g*8 +: 8]  = d_top[g];
        end
    end

    planar_pred16 dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_left(left_bus), .ref_top(top_bus),
        .ref_top_right(tr_in), .ref_bot_left(bl_in),
        .pred_sample(pred_sample), .pred_col(pred_col), .pred_row(pred_row),
        .pred_valid(pred_valid), .block_done(block_done)
    );

    function automatic int model(int i, int j);
        return ((15 - i) * int'(e_left[j]) + (i + 1) * int'(e_tr)
              + (15 - j) * int'(e_top[i]) + (j + 1) * int'(e_bl) + 16) >> 5;
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic set_uniform(input logic [7:0] l, input logic [7:0] t,
                               input logic [7:0] tr, input logic [7:0] bl);
        for (int g = 0; g < 16; g++) begin
            d_left[g] = l;
            d_top[g]  = t;
        end
        tr_in = tr;
        bl_in = bl;
    endtask

    task automatic set_random();
        for (int g = 0; g < 16; g++) begin
            d_left[g] = 8'($urandom);
            d_top[g]  = 8'($urandom);
        end
        tr_in = 8'($urandom);
        bl_in = 8'($urandom);
    endtask

    task automatic take_expect();
        for (int g = 0; g < 16; g++) begin
            e_left[g] = d_left[g];
            e_top[g]  = d_top[g];
        end
        e_tr = tr_in;
        e_bl = bl_in;
    endtask

    // Pulse start from idle; the output must not be valid yet (R2).
    task automatic start_block();
        take_expect();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!pred_valid, "R2", $sformatf("valid one cycle early: got %0b exp 0", pred_valid));
    endtask

    // Walk the 256 outputs; optionally poke an ignored start or chain the next block.
    task automatic scan_block(input bit done_first, input bit poke, input bit chain);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == 0) begin
                check(block_done == done_first, "R7",
                      $sformatf("done with first sample: got %0b exp %0b", block_done, done_first));
                first_pred = int'(pred_sample);
            end
            if (k == 255) last_pred = int'(pred_sample);
            check(pred_valid && pred_col == 4'(k % 16) && pred_row == 4'(k / 16)
                  && int'(pred_sample) == model(k % 16, k / 16),
                  (poke && k > 100) ? "R6" : "R4",
                  $sformatf("k=%0d got v=%0b col=%0d row=%0d s=%0d exp v=1 col=%0d row=%0d s=%0d (R3)",
                            k, pred_valid, pred_col, pred_row, pred_sample,
                            k % 16, k / 16, model(k % 16, k / 16)));
            if (poke && k == 100) begin
                for (int g = 0; g < 16; g++) begin
                    d_left[g] = ~e_left[g];
                    d_top[g]  = ~e_top[g];
                end
                tr_in = ~e_tr;
                bl_in = ~e_bl;
                start = 1'b1;
            end
            if (chain && k == 254) begin
                set_random();
                start = 1'b1;
            end
        end
        if (chain) take_expect();
    endtask

    task automatic check_tail();
        @(negedge clk);
        check(!pred_valid && block_done, "R5",
              $sformatf("after last: got v=%0b d=%0b exp v=0 d=1", pred_valid, block_done));
        @(negedge clk);
        check(!block_done, "R5", $sformatf("done width: got %0b exp 0", block_done));
    endtask

    initial begin
        #(10ns * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        set_uniform(8'd0, 8'd0, 8'd0, 8'd0);
        repeat (3) @(negedge clk);
        check(!pred_valid && !block_done && pred_col == 0 && pred_row == 0 && pred_sample == 0,
              "R1", $sformatf("reset outputs: got v=%0b d=%0b c=%0d r=%0d s=%0d exp all 0",
                              pred_valid, block_done, pred_col, pred_row, pred_sample));
        rst_n = 1'b1;
        @(negedge clk);

        // Table of uniform-reference vectors with hand-computed corners (R4, R8).
        for (int v = 0; v < 5; v++) begin
            set_uniform(VEC[v][47:40], VEC[v][39:32], VEC[v][31:24], VEC[v][23:16]);
            start_block();
            scan_block(1'b0, 1'b0, 1'b0);
            check(first_pred == int'(VEC[v][15:8]), "R8",
                  $sformatf("vec %0d (0,0): got %0d exp %0d", v, first_pred, VEC[v][15:8]));
            check(last_pred == int'(VEC[v][7:0]), "R8",
                  $sformatf("vec %0d (15,15): got %0d exp %0d", v, last_pred, VEC[v][7:0]));
            check_tail();
        end

        // Random references (R4).
        set_random();
        start_block();
        scan_block(1'b0, 1'b0, 1'b0);
        check_tail();

        // Start mid-scan with inverted references is ignored (R6).
        set_random();
        start_block();
        scan_block(1'b0, 1'b1, 1'b0);
        check_tail();

        // Back-to-back: done coincides with the next block's origin (R7).
        set_random();
        start_block();
        scan_block(1'b0, 1'b0, 1'b1);
        scan_block(1'b1, 1'b0, 1'b0);
        check_tail();

        // Reset mid-scan abandons the block without done (R1).
        set_random();
        start_block();
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!pred_valid && !block_done && pred_col == 0 && pred_row == 0 && pred_sample == 0,
              "R1", $sformatf("mid reset: got v=%0b d=%0b c=%0d r=%0d s=%0d exp all 0",
                              pred_valid, block_done, pred_col, pred_row, pred_sample));
        rst_n = 1'b1;
        begin
            int bad = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (pred_valid || block_done) bad++;
            end
            check(bad == 0, "R1", $sformatf("activity after reset: got %0d cycles exp 0", bad));
        end

        // Recovery after reset with all-255 references (R8).
        set_uniform(8'd255, 8'd255, 8'd255, 8'd255);
        start_block();
        scan_block(1'b0, 1'b0, 1'b0);
        check_tail();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule